// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Block

This block is a configurable AND-OR plane. A set of routed input signals becomes a pool of literals: each input appears once as itself and once inverted. Every product term in a fixed pool is the AND of whichever literals its enable mask selects. A steering stage then builds each output sum as the OR of any subset of the pool. A term is not owned by one output, so a single term can feed several sums.

The fuse pattern arrives on static configuration ports. There is one literal-enable mask per term and one term-select mask per sum. The block does not store that pattern or load it. The path from inputs to sums is purely combinational. Its depth is the same however many terms a sum uses or shares. A separate checker watches the term-select masks. It raises a flag when any sum asks for more terms than the per-sum cap allows.

Top module: `sop_logic_block`

## Requirements
- R1: Literal index 2*i of a term's enable mask is input i in true form, and index 2*i+1 is input i inverted. Term t's mask occupies bits [t*2*N_IN +: 2*N_IN] of `term_lit_en`.
- R2: A product term with no literal enabled evaluates to 1.
- R3: A term that enables both the true and the inverted literal of the same input evaluates to 0 for every input pattern.
- R4: A sum whose term-select mask is all zero drives 0. The mask of sum o is bits [o*N_TERMS +: N_TERMS] of `sum_term_sel`, and bit t selects term t.
- R5: One product term selected by several sums contributes to every one of them at the same time.
- R6: `config_error` is 1 exactly when some sum's term-select mask has more than MAX_TERMS bits set. Exactly MAX_TERMS bits set is legal.
- R7: The sums keep their AND-OR value whatever `config_error` shows.
- R8: For any configuration and any input vector, each sum equals the OR, over its selected terms, of the AND of each term's enabled literals.
- R9: A change on `sig_in` reaches `sum_out` with no clock edge in between. The block holds no registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sig_in | input | N_IN | Routed input signals |
| term_lit_en | input | N_TERMS*2*N_IN | Literal-enable mask per product term |
| sum_term_sel | input | N_OUT*N_TERMS | Term-select mask per sum output |
| sum_out | output | N_OUT | OR sums toward the macrocells |
| config_error | output | 1 | Some sum selects more than MAX_TERMS terms |

## Verification
The bench uses a small instance of 3 inputs, 8 terms, 4 sums and a cap of 3. Every configuration it applies is run against all eight input vectors. The corner cases are the empty term, the empty sum and the contradictory term. A design that tied an empty term low would lose constant-true sums. A design that let an empty sum float high would light outputs that have nothing selected. A design that swapped the true and inverted literal slots would invert single-literal sums.

The cap is probed at exactly the limit and one term past it. A comparison that was off by one would then flag a legal mask or pass an illegal one. Sharing is probed by selecting one term from every sum, which exposes an allocator that gives each term to one output only. Random sparse configurations, some of them over the cap, are then compared against an arithmetic model.

// File: rtl/sop_pkg.sv
package sop_pkg;

    // Number of bits needed to hold a count from 0 to n inclusive.
    function automatic int unsigned count_width(input int unsigned n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

    // Literal slots contributed by each routed input: true and inverted.
    localparam int unsigned LITS_PER_INPUT = 2;

endpackage

// File: rtl/sop_literal_gen.sv
module sop_literal_gen #(
    parameter int unsigned N_IN = 36
) (
    input  logic [N_IN-1:0]                         sig_in,
    output logic [N_IN*sop_pkg::LITS_PER_INPUT-1:0] lit_bus
);

    genvar gi;
    generate
        for (gi = 0; gi < N_IN; gi++) begin : g_lit
            // R1: even slot carries the true form, odd slot the inverted form
            assign lit_bus[2*gi]   = sig_in[gi];
            assign lit_bus[2*gi+1] = ~sig_in[gi];
        end
    endgenerate

endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
    parameter int unsigned N_IN    = 36,
    parameter int unsigned N_TERMS = 86
) (
    input  logic [N_IN*sop_pkg::LITS_PER_INPUT-1:0]         lit_bus,
    input  logic [N_TERMS*N_IN*sop_pkg::LITS_PER_INPUT-1:0] term_lit_en,
    output logic [N_TERMS-1:0]                              term_val
);

    localparam int unsigned N_LIT = N_IN * sop_pkg::LITS_PER_INPUT;

    genvar gt;
    generate
        for (gt = 0; gt < N_TERMS; gt++) begin : g_term
            logic [N_LIT-1:0] en_mask;
            logic             has_conflict;

            assign en_mask = term_lit_en[gt*N_LIT +: N_LIT];

            // A literal that is not enabled passes 1 into the AND.
            assign term_val[gt] = &(lit_bus | ~en_mask);

            always_comb begin
                has_conflict = 1'b0;
                for (int k = 0; k < N_IN; k++) begin
                    if (en_mask[2*k] && en_mask[2*k+1]) begin
                        has_conflict = 1'b1;
                    end
                end
            end

            always_comb begin
                if (en_mask == '0) begin
                    AST_EMPTY_TERM_ONE: assert (term_val[gt] == 1'b1); // R2
                end
                if (has_conflict) begin
                    AST_CONTRA_TERM_ZERO: assert (term_val[gt] == 1'b0); // R3
                end
            end
        end
    endgenerate

endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
    parameter int unsigned N_TERMS = 86,
    parameter int unsigned N_OUT   = 16
) (
    input  logic [N_TERMS-1:0]       term_val,
    input  logic [N_OUT*N_TERMS-1:0] sum_term_sel,
    output logic [N_OUT-1:0]         sum_out
);

    genvar go;
    generate
        for (go = 0; go < N_OUT; go++) begin : g_sum
            logic [N_TERMS-1:0] sel_mask;
            logic               any_live;

            assign sel_mask     = sum_term_sel[go*N_TERMS +: N_TERMS];
            assign sum_out[go]  = |(term_val & sel_mask);

            // Independent scan of the selected terms for the checks below.
            always_comb begin
                any_live = 1'b0;
                for (int t = 0; t < N_TERMS; t++) begin
                    if (sel_mask[t] && term_val[t]) begin
                        any_live = 1'b1;
                    end
                end
            end

            always_comb begin
                if (sel_mask == '0) begin
                    AST_EMPTY_SUM_ZERO: assert (sum_out[go] == 1'b0); // R4
                end
                AST_SUM_MATCHES_TERMS: assert (sum_out[go] == any_live); // R8
            end
        end
    endgenerate

endmodule

// File: rtl/sop_cfg_check.sv
module sop_cfg_check #(
    parameter int unsigned N_TERMS   = 86,
    parameter int unsigned N_OUT     = 16,
    parameter int unsigned MAX_TERMS = 16
) (
    input  logic [N_OUT*N_TERMS-1:0] sum_term_sel,
    output logic                     config_error
);

    localparam int unsigned CW = sop_pkg::count_width(N_TERMS);

    logic [N_OUT-1:0] over_cap;

    genvar go;
    generate
        for (go = 0; go < N_OUT; go++) begin : g_cnt
            logic [CW-1:0] sel_count;

            always_comb begin
                sel_count = '0;
                for (int t = 0; t < N_TERMS; t++) begin
                    sel_count = sel_count + CW'(sum_term_sel[go*N_TERMS + t]);
                end
            end

            assign over_cap[go] = (32'(sel_count) > MAX_TERMS);
        end
    endgenerate

    assign config_error = |over_cap;

    always_comb begin
        if (over_cap == '0) begin
            AST_NO_FALSE_ERROR: assert (config_error == 1'b0); // R6
        end
    end

endmodule

// File: rtl/sop_logic_block.sv
module sop_logic_block #(
    parameter int unsigned N_IN      = 36,
    parameter int unsigned N_TERMS   = 86,
    parameter int unsigned N_OUT     = 16,
    parameter int unsigned MAX_TERMS = 16
) (
    input  logic [N_IN-1:0]                                 sig_in,
    input  logic [N_TERMS*N_IN*sop_pkg::LITS_PER_INPUT-1:0] term_lit_en,
    input  logic [N_OUT*N_TERMS-1:0]                        sum_term_sel,
    output logic [N_OUT-1:0]                                sum_out,
    output logic                                            config_error
);

    localparam int unsigned N_LIT = N_IN * sop_pkg::LITS_PER_INPUT;

    logic [N_LIT-1:0]   lit_bus;
    logic [N_TERMS-1:0] term_val;

    sop_literal_gen #(
        .N_IN (N_IN)
    ) u_lit (
        .sig_in  (sig_in),
        .lit_bus (lit_bus)
    );

    sop_and_plane #(
        .N_IN    (N_IN),
        .N_TERMS (N_TERMS)
    ) u_and (
        .lit_bus     (lit_bus),
        .term_lit_en (term_lit_en),
        .term_val    (term_val)
    );

    // R5, R7: the OR plane reads the shared term pool and ignores the cap flag
    sop_or_plane #(
        .N_TERMS (N_TERMS),
        .N_OUT   (N_OUT)
    ) u_or (
        .term_val     (term_val),
        .sum_term_sel (sum_term_sel),
        .sum_out      (sum_out)
    );

    sop_cfg_check #(
        .N_TERMS   (N_TERMS),
        .N_OUT     (N_OUT),
        .MAX_TERMS (MAX_TERMS)
    ) u_chk (
        .sum_term_sel (sum_term_sel),
        .config_error (config_error)
    );

    // R1: a term enabling only slot 0 follows input 0 in true form
    always_comb begin
        if (term_lit_en[N_LIT-1:0] == N_LIT'(1)) begin
            AST_TRUE_SLOT_ORDER: assert (term_val[0] == sig_in[0]); // R1
        end
    end

endmodule

// File: tb/sop_logic_block_bench.sv
module sop_logic_block_bench;

    localparam int unsigned N_IN  = 3;
    localparam int unsigned N_T   = 8;
    localparam int unsigned N_O   = 4;
    localparam int unsigned MAXT  = 3;
    localparam int unsigned N_L   = 2 * N_IN;

    logic                clk = 1'b0;
    logic [N_IN-1:0]     sig_in = '0;
    logic [N_T*N_L-1:0]  term_lit_en = '0;
    logic [N_O*N_T-1:0]  sum_term_sel = '0;
    logic [N_O-1:0]      sum_out;
    logic                config_error;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    sop_logic_block #(
        .N_IN (N_IN), .N_TERMS (N_T), .N_OUT (N_O), .MAX_TERMS (MAXT)
    ) u_sop_logic_block (
        .sig_in       (sig_in),
        .term_lit_en  (term_lit_en),
        .sum_term_sel (sum_term_sel),
        .sum_out      (sum_out),
        .config_error (config_error)
    );

    function automatic logic [N_O-1:0] model_sum(input logic [N_IN-1:0] x);
        logic [N_T-1:0] tv;
        logic [N_O-1:0] s;
        for (int t = 0; t < N_T; t++) begin
            tv[t] = 1'b1;
            for (int i = 0; i < N_IN; i++) begin
                if (term_lit_en[t*N_L + 2*i]   && !x[i]) tv[t] = 1'b0;
                if (term_lit_en[t*N_L + 2*i+1] &&  x[i]) tv[t] = 1'b0;
            end
        end
        for (int o = 0; o < N_O; o++) begin
            s[o] = 1'b0;
            for (int t = 0; t < N_T; t++) begin
                if (sum_term_sel[o*N_T + t] && tv[t]) s[o] = 1'b1;
            end
        end
        return s;
    endfunction

    function automatic logic model_err();
        logic e = 1'b0;
        for (int o = 0; o < N_O; o++) begin
            int c = 0;
            for (int t = 0; t < N_T; t++) c += int'(sum_term_sel[o*N_T + t]);
            if (c > int'(MAXT)) e = 1'b1;
        end
        return e;
    endfunction

    task automatic cmp(input string req, input logic [N_O-1:0] act, input logic [N_O-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Drive each of the 8 vectors after a falling edge, sample 1 ns later (before the rise).
    task automatic sweep(input string req);
        for (int v = 0; v < (1 << N_IN); v++) begin
            @(negedge clk);
            sig_in = N_IN'(v);
            #1;
            cmp(req, sum_out, model_sum(N_IN'(v)));
            cmp(req, {3'b000, config_error}, {3'b000, model_err()});
        end
    endtask

    task automatic clear_cfg();
        term_lit_en  = '0;
        sum_term_sel = '0;
    endtask

    initial begin
        // Zero configuration: every sum is empty (R4), no cap violation (R6)
        clear_cfg();
        sweep("R4");

        // R1: term0 = x0 true, term1 = x1 inverted, term2 = x2 true
        clear_cfg();
        term_lit_en[0*N_L + 0] = 1'b1;
        term_lit_en[1*N_L + 3] = 1'b1;
        term_lit_en[2*N_L + 4] = 1'b1;
        sum_term_sel[0*N_T + 0] = 1'b1;
        sum_term_sel[1*N_T + 1] = 1'b1;
        sum_term_sel[2*N_T + 2] = 1'b1;
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            sig_in = 3'(v);
            #1;
            cmp("R1", sum_out[2:0], {sig_in[2], ~sig_in[1], sig_in[0]});
        end

        // R2: empty term selected by sum 0 is constant 1
        clear_cfg();
        sum_term_sel[0*N_T + 5] = 1'b1;
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            sig_in = 3'(v);
            #1;
            cmp("R2", sum_out, 4'b0001);
        end

        // R3: term enabling x1 and ~x1 is constant 0
        clear_cfg();
        term_lit_en[4*N_L + 2] = 1'b1;
        term_lit_en[4*N_L + 3] = 1'b1;
        sum_term_sel[3*N_T + 4] = 1'b1;
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            sig_in = 3'(v);
            #1;
            cmp("R3", sum_out, 4'b0000);
        end

        // R5: term6 = x0 & ~x2 shared by all four sums
        clear_cfg();
        term_lit_en[6*N_L + 0] = 1'b1;
        term_lit_en[6*N_L + 5] = 1'b1;
        for (int o = 0; o < N_O; o++) sum_term_sel[o*N_T + 6] = 1'b1;
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            sig_in = 3'(v);
            #1;
            cmp("R5", sum_out, {4{sig_in[0] & ~sig_in[2]}});
        end

        // R6: exactly MAXT terms on sum 1 is legal, one more flags an error
        clear_cfg();
        term_lit_en[0*N_L + 1] = 1'b1;
        term_lit_en[1*N_L + 2] = 1'b1;
        term_lit_en[2*N_L + 4] = 1'b1;
        term_lit_en[3*N_L + 0] = 1'b1;
        for (int t = 0; t < 3; t++) sum_term_sel[1*N_T + t] = 1'b1;
        @(negedge clk);
        #1;
        cmp("R6", {3'b000, config_error}, 4'b0000);
        sum_term_sel[1*N_T + 3] = 1'b1;
        #1;
        cmp("R6", {3'b000, config_error}, 4'b0001);

        // R7: with the flag raised, sum 1 is still ~x0 | x1 | x2 | x0
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            sig_in = 3'(v);
            #1;
            cmp("R7", sum_out, {2'b00, 1'b1, 1'b0});
        end

        // R9: no clock edge between input change and sample
        clear_cfg();
        term_lit_en[0*N_L + 2] = 1'b1;
        sum_term_sel[2*N_T + 0] = 1'b1;
        @(posedge clk);
        #0.5;
        sig_in = 3'b010;
        #0.5;
        cmp("R9", sum_out, 4'b0100);
        sig_in = 3'b000;
        #0.5;
        cmp("R9", sum_out, 4'b0000);

        // R8: random sparse configurations, some over the cap
        for (int c = 0; c < 400; c++) begin
            clear_cfg();
            for (int b = 0; b < int'(N_T*N_L); b++) term_lit_en[b] = (($urandom % 5) == 0);
            for (int b = 0; b < int'(N_O*N_T); b++) sum_term_sel[b] = (($urandom % 4) == 0);
            if (c % 3 == 0) begin
                for (int o = 1; o < N_O; o++) sum_term_sel[o*N_T + (c % N_T)] = 1'b1;
            end
            sweep("R8");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule